// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block gives two independent ports, called left and right, a shared bank of hardware semaphore flags for mutual exclusion. Each port picks one flag with an index. A port asks for the token by writing a 0 on data bit 0 and gives it back by writing a 1. Reading a flag returns that port's own view of it, repeated across the whole data word. A port reads 0 only while it holds the token; otherwise it reads 1.

A port that asks for a flag held by the other side is not refused. Its request is stored, and it gets the token automatically on the cycle the holder releases it. Software on the waiting side can poll its read value until it turns to 0. A port that changes its mind withdraws the stored request by writing 1. Writes take effect at the clock edge, and reads show the registered state combinationally for the index currently presented.

Top module: `semFlags`

## Requirements
- R1: After reset every flag is free, and both ports read all ones for every index.
- R2: A read returns the flag view copied onto all DATA_W bits: all zeros when the reading port holds the token, and all ones otherwise.
- R3: Only bit 0 of the write data is used. The upper bits have no effect on the flag state.
- R4: A 0 written to a free flag gives the token to the writer from the next cycle. The writer then reads 0 and the other port reads 1.
- R5: A 0 written by the port that does not hold the token changes nothing visible: the holder keeps reading 0 and the writer keeps reading 1. At no time do both ports read 0 for the same index.
- R6: When the holder writes 1 while the other port has a stored request, the token moves to the other port on the next cycle. The old holder then reads 1 and the new holder reads 0.
- R7: When the holder writes 1 and no request is stored, the flag becomes free and both ports read 1.
- R8: A 1 written by the port that does not hold the token cancels its own stored request and leaves the holder unaffected. A later release by the holder then frees the flag.
- R9: If both ports write 0 to a free flag in the same cycle, the left port gets the token and the right port's request is stored.
- R10: The NUM_SEM flags are independent. A write changes only the flag at the written index.
- R11: A 0 written by the holder to its own flag changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lWr | input | 1 | Left port write strobe |
| lSel | input | IDX_W | Left port flag index |
| lWrData | input | DATA_W | Left port write data (bit 0 used) |
| lRdData | output | DATA_W | Left port read view of the selected flag |
| rWr | input | 1 | Right port write strobe |
| rSel | input | IDX_W | Right port flag index |
| rWrData | input | DATA_W | Right port write data (bit 0 used) |
| rRdData | output | DATA_W | Right port read view of the selected flag |

## Verification
The bench builds the block with its default parameters: eight flags, a 3-bit index and a 16-bit data word. With these values every index, including the top one, can be reached, and the replication check covers a full 16-bit word. Directed sequences walk one flag through each ownership transition: take, blocked request, hand-over, cancel, same-cycle contention and release. A long random phase then mixes writes on both ports over all eight flags, and the behavioural model is compared against both read ports on every clock.

// File: rtl/semPkg.sv
package semPkg;
  typedef struct packed {
    logic held;   // token is owned by some port
    logic ownR;   // 1: right owns, 0: left owns (valid when held)
    logic pendL;  // left waits for the token
    logic pendR;  // right waits for the token
  } semState_t;

  typedef struct packed {
    logic takeL;
    logic takeR;
    logic freeIt;
    logic setPendL;
    logic clrPendL;
    logic setPendR;
    logic clrPendR;
  } semStrobe_t;
endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic                     lWr,
  input  logic [IDX_W-1:0]         lSel,
  input  logic                     lBit,
  input  logic                     rWr,
  input  logic [IDX_W-1:0]         rSel,
  input  logic                     rBit,
  input  semState_t  [NUM_SEM-1:0] st,
  output semStrobe_t [NUM_SEM-1:0] strb
);
  for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
    logic hitL, hitR, reqL, reqR, relL, relR;
    assign hitL = lWr && (lSel == IDX_W'(i));
    assign hitR = rWr && (rSel == IDX_W'(i));
    assign reqL = hitL && !lBit;
    assign relL = hitL && lBit;
    assign reqR = hitR && !rBit;
    assign relR = hitR && rBit;

    always_comb begin
      strb[i] = '0;
      if (!st[i].held) begin
        // free: left wins a tie, right request is remembered
        strb[i].takeL    = reqL;
        strb[i].takeR    = reqR && !reqL;
        strb[i].setPendR = reqL && reqR;
      end else if (!st[i].ownR) begin
        strb[i].setPendR = reqR;
        strb[i].clrPendR = relR;
        if (relL) begin
          if (reqR || (st[i].pendR && !relR)) strb[i].takeR  = 1'b1;
          else                                strb[i].freeIt = 1'b1;
        end
      end else begin
        strb[i].setPendL = reqL;
        strb[i].clrPendL = relL;
        if (relR) begin
          if (reqL || (st[i].pendL && !relL)) strb[i].takeL  = 1'b1;
          else                                strb[i].freeIt = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  semStrobe_t [NUM_SEM-1:0] strb,
  input  logic [IDX_W-1:0]         lSel,
  input  logic [IDX_W-1:0]         rSel,
  output semState_t  [NUM_SEM-1:0] st,
  output logic [DATA_W-1:0]        lRdData,
  output logic [DATA_W-1:0]        rRdData
);
  for (genvar i = 0; i < NUM_SEM; i++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st[i] <= '0;
      end else begin
        if (strb[i].setPendL) st[i].pendL <= 1'b1;
        if (strb[i].clrPendL) st[i].pendL <= 1'b0;
        if (strb[i].setPendR) st[i].pendR <= 1'b1;
        if (strb[i].clrPendR) st[i].pendR <= 1'b0;
        if (strb[i].freeIt)   st[i].held  <= 1'b0;
        if (strb[i].takeL) begin
          st[i].held  <= 1'b1;
          st[i].ownR  <= 1'b0;
          st[i].pendL <= 1'b0;
        end
        if (strb[i].takeR) begin
          st[i].held  <= 1'b1;
          st[i].ownR  <= 1'b1;
          st[i].pendR <= 1'b0;
        end
      end
    end
  end

  logic lView, rView;
  always_comb begin
    lView = !(st[lSel].held && !st[lSel].ownR);
    rView = !(st[rSel].held &&  st[rSel].ownR);
  end
  assign lRdData = {DATA_W{lView}};
  assign rRdData = {DATA_W{rView}};
endmodule

// File: rtl/semFlags.sv
module semFlags
  import semPkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lWr,
  input  logic [IDX_W-1:0]  lSel,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rWr,
  input  logic [IDX_W-1:0]  rSel,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData
);
  semState_t  [NUM_SEM-1:0] semSt;
  semStrobe_t [NUM_SEM-1:0] semStrb;

  semCtrl #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_ctrl (
    .lWr(lWr), .lSel(lSel), .lBit(lWrData[0]),
    .rWr(rWr), .rSel(rSel), .rBit(rWrData[0]),
    .st(semSt), .strb(semStrb)
  );

  semDatapath #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(semStrb),
    .lSel(lSel), .rSel(rSel), .st(semSt),
    .lRdData(lRdData), .rRdData(rRdData)
  );
endmodule

// File: rtl/semFlagsChk.sv
module semFlagsChk #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              lWr,
  input logic [IDX_W-1:0]  lSel,
  input logic [DATA_W-1:0] lWrData,
  input logic [DATA_W-1:0] lRdData,
  input logic              rWr,
  input logic [IDX_W-1:0]  rSel,
  input logic [DATA_W-1:0] rWrData,
  input logic [DATA_W-1:0] rRdData
);
  // R1
  reset_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (lRdData[0] && rRdData[0]));

  // R2
  read_replicate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lRdData == {DATA_W{lRdData[0]}}) && (rRdData == {DATA_W{rRdData[0]}}));

  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lSel == rSel) |-> (lRdData[0] || rRdData[0]));

  // R4
  grant_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && !lWrData[0] && lSel == rSel && lRdData[0] && rRdData[0])
    |=> (!$stable(lSel) || !lRdData[0]));

  // R7
  release_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lWr && lWrData[0] && !lRdData[0]) |=> (!$stable(lSel) || lRdData[0]));

  // R5
  holder_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rWr && lSel == rSel && !lRdData[0] && !(lWr && lWrData[0]))
    |=> (!$stable(lSel) || !lRdData[0]));
endmodule

bind semFlags semFlagsChk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN),
  .lWr(lWr), .lSel(lSel), .lWrData(lWrData), .lRdData(lRdData),
  .rWr(rWr), .rSel(rSel), .rWrData(rWrData), .rRdData(rRdData)
);

// File: tb/semFlags_tb.sv
module semFlags_tb;
  localparam int NS = 8;
  localparam int DW = 16;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lWr = 1'b0, rWr = 1'b0;
  logic [IW-1:0] lSel = '0, rSel = '0;
  logic [DW-1:0] lWrData = '0, rWrData = '0;
  logic [DW-1:0] lRdData, rRdData;

  int tests = 0;
  int fails = 0;

  // model: owner -1 free, 0 left, 1 right
  int owner[NS];
  bit pend[2][NS];

  always #5 clk = ~clk;

  semFlags #(.NUM_SEM(NS), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rstN(rstN),
    .lWr(lWr), .lSel(lSel), .lWrData(lWrData), .lRdData(lRdData),
    .rWr(rWr), .rSel(rSel), .rWrData(rWrData), .rRdData(rRdData)
  );

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  function automatic void modelClock(bit lw, int ls, bit lb, bit rw, int rs, bit rb);
    bit req[2], rel[2];
    for (int i = 0; i < NS; i++) begin
      req[0] = lw && ls == i && !lb; rel[0] = lw && ls == i && lb;
      req[1] = rw && rs == i && !rb; rel[1] = rw && rs == i && rb;
      if (owner[i] < 0) begin
        if (req[0]) begin owner[i] = 0; pend[1][i] = req[1]; end
        else if (req[1]) owner[i] = 1;
      end else begin
        int o = owner[i];
        int x = 1 - o;
        if (req[x]) pend[x][i] = 1'b1;
        if (rel[x]) pend[x][i] = 1'b0;
        if (rel[o]) begin
          if (pend[x][i]) begin owner[i] = x; pend[x][i] = 1'b0; end
          else owner[i] = -1;
        end
      end
    end
  endfunction

  task automatic checkReads(string tag);
    logic [DW-1:0] expL, expR;
    expL = {DW{owner[lSel] != 0}};
    expR = {DW{owner[rSel] != 1}};
    tests++;
    if (lRdData !== expL || rRdData !== expR) begin
      fails++;
      $display("FAIL %s: sel L=%0d R=%0d got L=%h R=%h expected L=%h R=%h",
               tag, lSel, rSel, lRdData, rRdData, expL, expR);
    end
  endtask

  task automatic step(bit lw, int ls, logic [DW-1:0] ld,
                      bit rw, int rs, logic [DW-1:0] rd, string tag);
    @(negedge clk);
    lWr = lw; lSel = IW'(ls); lWrData = ld;
    rWr = rw; rSel = IW'(rs); rWrData = rd;
    #1 checkReads(tag);
    @(posedge clk);
    modelClock(lw, ls, ld[0], rw, rs, rd[0]);
  endtask

  // read-only look at one index from both ports
  task automatic peek(int s, string tag);
    step(0, s, '0, 0, s, '0, tag);
  endtask

  localparam logic [DW-1:0] TAKE = 16'hFFFE; // bit0=0, noise above (R3)
  localparam logic [DW-1:0] GIVE = 16'h0001; // bit0=1

  initial begin
    for (int i = 0; i < NS; i++) begin owner[i] = -1; pend[0][i] = 0; pend[1][i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state on every index
    for (int i = 0; i < NS; i++) peek(i, "R1");
    // R4 left takes flag 3 with noisy upper bits (R3)
    step(1, 3, TAKE, 0, 3, '0, "R4");
    peek(3, "R4");
    // R5 right asks while left holds; R2 replicated read
    step(0, 3, '0, 1, 3, 16'h5A5A, "R5");
    peek(3, "R5");
    // R11 holder repeats its request
    step(1, 3, 16'h0000, 0, 3, '0, "R11");
    peek(3, "R11");
    // R10 flag 5 independent of flag 3
    step(0, 5, '0, 1, 5, TAKE, "R10");
    peek(5, "R10"); peek(3, "R10");
    // R6 left releases, right's stored request is granted
    step(1, 3, GIVE, 0, 3, '0, "R6");
    peek(3, "R6");
    // R5 left requests while right holds, then right releases -> R6
    step(1, 3, TAKE, 0, 3, '0, "R5");
    step(0, 3, '0, 1, 3, 16'hFFFF, "R6");
    peek(3, "R6");
    // R7 left releases with no request stored
    step(1, 3, GIVE, 0, 3, '0, "R7");
    peek(3, "R7");
    // R8 right requests, cancels, left releases -> free
    step(1, 2, TAKE, 0, 2, '0, "R8");
    step(0, 2, '0, 1, 2, TAKE, "R8");
    step(0, 2, '0, 1, 2, 16'h8001, "R8");
    peek(2, "R8");
    step(1, 2, GIVE, 0, 2, '0, "R8");
    peek(2, "R8");
    // R3 upper bits alone do nothing: bit0=1 on free flag
    step(1, 6, 16'hFFFF, 1, 6, 16'h7FFF, "R3");
    peek(6, "R3");
    // R9 same-cycle request on free flag 7
    step(1, 7, TAKE, 1, 7, TAKE, "R9");
    peek(7, "R9");
    step(1, 7, GIVE, 0, 7, '0, "R9");
    peek(7, "R9");
    // R6 hand-over in the same cycle as a fresh request
    step(0, 7, '0, 1, 7, GIVE, "R7");
    step(1, 1, TAKE, 0, 1, '0, "R4");
    step(1, 1, GIVE, 1, 1, TAKE, "R6");
    peek(1, "R6");
    // random mix, compared every clock
    for (int n = 0; n < 3000; n++) begin
      step(1'($urandom), int'($urandom % NS), DW'($urandom),
           1'($urandom), int'($urandom % NS), DW'($urandom), "R10");
    end
    for (int i = 0; i < NS; i++) peek(i, "R2");
    finishRun();
  end
endmodule